// File: doc/BRIEF.md
# SDRAM Mode-Register Command Timing Guard

This block sits between the command scheduler of a DDR SDRAM controller and the command bus to the memory. Each command the scheduler presents is checked against the rules that govern mode register writes, precharge recovery and DLL relock. A legal command passes to the bus in the same cycle. An illegal one is held: `cmd_ready` stays low and the bus carries a NOP. Once every blocking wait has run out, the same command goes out unchanged.

The guard keeps three kinds of state. The first is a per-bank open/closed map, fed by activates and precharges. The second is a pair of programmable down-counters for the precharge recovery time (`cfg_trp`) and the mode-register recovery time (`cfg_tmrd`). The third is a fixed-length DLL lock counter. That counter, together with an "enabled at least once" flag, gates READ commands after the DLL is switched on or after the device leaves self-refresh.

Command codes on `cmd_kind` / `bus_kind` are: NOP=0, ACT=1, READ=2, WRITE=3, PRE (one bank)=4, PREALL=5, MRS=6, EMRS=7, SRX (self-refresh exit)=8. Any other code is forwarded at once and has no effect. A command is issued at a rising edge where `cmd_valid` and `cmd_ready` are both high.

Top module: `sdram_mrs_guard`

## Requirements
- R1: After reset all banks count as closed and all counters are zero, so MRS/EMRS is ready at once. READ is refused until the DLL has been enabled at least once.
- R2: MRS (6) and EMRS (7) are refused while any bank is open. ACT (1) opens the addressed bank, PRE (4) closes only the addressed bank, and PREALL (5) closes every bank.
- R3: If PRE or PREALL issues at edge e, an otherwise legal MRS/EMRS issues no earlier than edge e+max(tRP,1). It issues exactly there when held waiting.
- R4: If MRS or EMRS issues at edge e, every following non-NOP command issues no earlier than edge e+max(tMRD,1). It issues exactly there when held waiting.
- R5: If EMRS issues with `cmd_dll_on`=1 at edge e, READ (2) is refused until edge e+200 and is issued at that edge when held waiting.
- R6: If SRX (8) issues at edge e, READ is likewise refused until edge e+200.
- R7: EMRS with `cmd_dll_on`=0 neither starts nor restarts the READ lockout.
- R8: A refused command drives NOP on `bus_kind` and low `cmd_ready`. At its first legal edge it appears on the bus with its kind, bank and DLL bit unchanged.
- R9: The DLL lockout blocks only READ. WRITE and other commands pass during it.
- R10: NOP is always ready and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_trp | input | TIM_W | Precharge recovery time in cycles |
| cfg_tmrd | input | TIM_W | Mode-register recovery time in cycles |
| cmd_valid | input | 1 | Scheduler presents a command |
| cmd_kind | input | 4 | Command code |
| cmd_bank | input | BANK_W | Target bank for ACT/PRE |
| cmd_dll_on | input | 1 | EMRS argument: 1 enables the DLL, 0 disables it |
| cmd_ready | output | 1 | Presented command is legal this cycle |
| bus_kind | output | 4 | Command placed on the bus (NOP when nothing issues) |
| bus_bank | output | BANK_W | Bank field toward the bus |
| bus_dll_on | output | 1 | DLL argument toward the bus |

## Verification
Two waits can expire on the same edge. The first case is an MRS that waits on both an open bank and the precharge recovery count. The second is a READ held through the DLL lockout while the mode-register recovery count from a preceding EMRS also runs. The bench provokes these by sweeping tRP and tMRD through small values and keeping the command presented through every blocked cycle. It judges the case by the exact edge at which the command leaves, which must match the later of the two expiry edges computed arithmetically in the bench.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_PRE  = 4'd4,
    CMD_PALL = 4'd5,
    CMD_MRS  = 4'd6,
    CMD_EMRS = 4'd7,
    CMD_SRX  = 4'd8
  } cmd_e;

  // Counter preload for a minimum edge distance of max(t,1).
  function automatic int unsigned gap_preload(input int unsigned t);
    return (t == 0) ? 0 : t - 1;
  endfunction

  function automatic logic is_mode_write(input logic [3:0] k);
    return (k == CMD_MRS) || (k == CMD_EMRS);
  endfunction

  // Legality of one command given the guard state.
  function automatic logic cmd_legal(input logic [3:0] k,
                                     input logic       tmrd_done,
                                     input logic       trp_done,
                                     input logic       all_closed,
                                     input logic       read_ok);
    logic ok;
    ok = 1'b1;
    if (k != CMD_NOP) begin
      if (!tmrd_done) ok = 1'b0;
      else if (is_mode_write(k)) ok = all_closed && trp_done;
      else if (k == CMD_RD) ok = read_ok;
    end
    return ok;
  endfunction

endpackage

// File: rtl/guard_down_counter.sv
module guard_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/guard_bank_tracker.sv
module guard_bank_tracker #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_act,
  input  logic              ev_pre,
  input  logic              ev_pall,
  input  logic [BANK_W-1:0] bank,
  output logic              all_closed
);
  logic [NUM_BANKS-1:0] open_map;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        open_map[b] <= 1'b0;
      else if (ev_pall || (ev_pre && hit)) open_map[b] <= 1'b0;
      else if (ev_act && hit)            open_map[b] <= 1'b1;
    end
  end

  assign all_closed = (open_map == '0);
endmodule

// File: rtl/sdram_mrs_guard.sv
module sdram_mrs_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TIM_W     = 6,
  parameter int DLL_LOCK  = 200,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int DLL_W  = $clog2(DLL_LOCK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIM_W-1:0]  cfg_trp,
  input  logic [TIM_W-1:0]  cfg_tmrd,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_kind,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_dll_on,
  output logic              cmd_ready,
  output logic [3:0]        bus_kind,
  output logic [BANK_W-1:0] bus_bank,
  output logic              bus_dll_on
);
  // Named internal events, visible to the bound checker.
  logic fire, ev_act, ev_pre, ev_pall, ev_mode, ev_dll_on, ev_srx;
  logic all_closed, trp_done, tmrd_done, lock_done, read_ok;
  logic dll_seen;

  assign fire      = cmd_valid && cmd_ready;
  assign ev_act    = fire && (cmd_kind == CMD_ACT);
  assign ev_pre    = fire && (cmd_kind == CMD_PRE);
  assign ev_pall   = fire && (cmd_kind == CMD_PALL);
  assign ev_mode   = fire && is_mode_write(cmd_kind);
  assign ev_dll_on = fire && (cmd_kind == CMD_EMRS) && cmd_dll_on;
  assign ev_srx    = fire && (cmd_kind == CMD_SRX);

  guard_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk, .rst_n,
    .ev_act, .ev_pre, .ev_pall,
    .bank(cmd_bank),
    .all_closed
  );

  guard_down_counter #(.W(TIM_W)) u_trp (
    .clk, .rst_n,
    .load(ev_pre || ev_pall),
    .load_val(TIM_W'(gap_preload(int'(cfg_trp)))),
    .done(trp_done)
  );

  guard_down_counter #(.W(TIM_W)) u_tmrd (
    .clk, .rst_n,
    .load(ev_mode),
    .load_val(TIM_W'(gap_preload(int'(cfg_tmrd)))),
    .done(tmrd_done)
  );

  guard_down_counter #(.W(DLL_W)) u_lock (
    .clk, .rst_n,
    .load(ev_dll_on || ev_srx),
    .load_val(DLL_W'(gap_preload(DLL_LOCK))),
    .done(lock_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   dll_seen <= 1'b0;
    else if (ev_dll_on || ev_srx) dll_seen <= 1'b1;
  end

  assign read_ok   = dll_seen && lock_done;
  assign cmd_ready = cmd_legal(cmd_kind, tmrd_done, trp_done, all_closed, read_ok);

  assign bus_kind   = fire ? cmd_kind : 4'(CMD_NOP);
  assign bus_bank   = cmd_bank;
  assign bus_dll_on = cmd_dll_on;
endmodule

// File: rtl/sdram_mrs_guard_chk.sv
module sdram_mrs_guard_chk
  import sdram_guard_pkg::*;
#(
  parameter int TIM_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [3:0]       bus_kind,
  input logic             all_closed,
  input logic             trp_done,
  input logic             read_ok,
  input logic [TIM_W-1:0] cfg_tmrd
);
  a_r2_mode_only_closed: assert property (@(posedge clk) disable iff (!rst_n)
    is_mode_write(bus_kind) |-> all_closed && trp_done);

  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_kind == CMD_ACT) |=> !all_closed);

  a_r4_tmrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mode_write(bus_kind) && cfg_tmrd > TIM_W'(1)) |=> (bus_kind == CMD_NOP));

  a_r5_read_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_kind == CMD_RD) |-> read_ok);

  a_r8_hold_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |-> (bus_kind == CMD_NOP));
endmodule

bind sdram_mrs_guard sdram_mrs_guard_chk #(.TIM_W(TIM_W)) u_chk (
  .clk, .rst_n, .cmd_valid, .cmd_ready, .bus_kind,
  .all_closed, .trp_done, .read_ok, .cfg_tmrd
);

// File: tb/sdram_mrs_guard_bench.sv
module sdram_mrs_guard_bench;
  localparam int TIM_W = 6;
  localparam int LOCK  = 200;

  logic clk = 0, rst_n = 0;
  logic [TIM_W-1:0] cfg_trp = '0, cfg_tmrd = '0;
  logic cmd_valid = 0, cmd_dll_on = 0;
  logic [3:0] cmd_kind = 0;
  logic [1:0] cmd_bank = 0;
  logic cmd_ready, bus_dll_on;
  logic [3:0] bus_kind;
  logic [1:0] bus_bank;

  int n_chk = 0, n_fail = 0, cyc = 0;

  sdram_mrs_guard u_sdram_mrs_guard (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gap(input int t);
    return (t < 1) ? 1 : t;
  endfunction

  // Present a command until accepted; return the issue edge number.
  task automatic send(input int k, input int b, input bit d, output int e);
    int guard;
    guard = 0;
    cmd_valid = 1; cmd_kind = 4'(k); cmd_bank = 2'(b); cmd_dll_on = d;
    #1;
    while (!cmd_ready && guard < 5000) begin
      @(negedge clk); #1; guard++;
    end
    chk(cmd_ready, "R8 accepted", int'(cmd_ready), 1);
    chk(bus_kind == 4'(k) && bus_bank == 2'(b) && bus_dll_on == d,
        "R8 forwarded unchanged", int'(bus_kind), k);
    e = cyc + 1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0; cmd_kind = 0;
  endtask

  task automatic hold_blocked(input int k, input int b, input int n, input string req);
    bit all_ok;
    all_ok = 1;
    cmd_valid = 1; cmd_kind = 4'(k); cmd_bank = 2'(b); cmd_dll_on = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      if (cmd_ready || bus_kind != 0) all_ok = 0;
      @(negedge clk);
    end
    chk(all_ok, req, int'(cmd_ready), 0);
    cmd_valid = 0; cmd_kind = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int e0, e1, e2, e3;
    idle(3); rst_n = 1; idle(1);

    // R1: mode write ready right after reset, READ refused
    cmd_kind = 4'd6; #1;
    chk(cmd_ready, "R1 MRS ready after reset", int'(cmd_ready), 1);
    cmd_kind = 4'd0; @(negedge clk);
    hold_blocked(2, 0, 300, "R1 READ blocked before DLL enable");

    // R10: NOP always ready, no bus activity
    cmd_valid = 1; cmd_kind = 0; #1;
    chk(cmd_ready && bus_kind == 0, "R10 NOP ready", int'(cmd_ready), 1);
    cmd_valid = 0; @(negedge clk);

    // R3 / R4 sweep over tRP and tMRD
    for (int trp = 0; trp < 5; trp++) begin
      for (int tm = 0; tm < 5; tm++) begin
        cfg_trp = TIM_W'(trp); cfg_tmrd = TIM_W'(tm);
        idle(8);
        send(5, 0, 0, e0);
        send(6, 0, 0, e1);
        chk(e1 - e0 == gap(trp), "R3 PREALL to MRS distance", e1 - e0, gap(trp));
        send(7, 0, 0, e2);
        chk(e2 - e1 == gap(tm), "R4 MRS to EMRS distance", e2 - e1, gap(tm));
      end
    end

    // R2: open banks block mode writes; single-bank PRE closes one bank
    cfg_trp = 3; cfg_tmrd = 2; idle(8);
    send(1, 0, 0, e0);
    send(1, 1, 0, e0);
    send(4, 0, 0, e0);
    hold_blocked(6, 0, 8, "R2 MRS blocked with bank 1 open");
    send(4, 1, 0, e1);
    send(6, 0, 0, e2);
    chk(e2 - e1 == 3, "R3 single PRE to MRS distance", e2 - e1, 3);
    // R4: non-mode command also waits tMRD
    send(1, 2, 0, e3);
    chk(e3 - e2 == 2, "R4 MRS to ACT distance", e3 - e2, 2);
    send(5, 0, 0, e0);

    // R5: DLL enable lockout
    idle(5);
    send(7, 0, 1, e0);
    send(2, 0, 0, e1);
    chk(e1 - e0 == LOCK, "R5 EMRS-on to READ distance", e1 - e0, LOCK);

    // R7: DLL disable starts no lockout
    send(7, 0, 0, e2);
    send(2, 0, 0, e3);
    chk(e3 - e2 == 2, "R7 READ after EMRS-off waits only tMRD", e3 - e2, 2);

    // R6 + R9: self-refresh exit lockout, WRITE passes through it
    send(8, 0, 0, e0);
    send(3, 0, 0, e1);
    chk(e1 - e0 == 1, "R9 WRITE during lockout", e1 - e0, 1);
    send(2, 0, 0, e2);
    chk(e2 - e0 == LOCK, "R6 SRX to READ distance", e2 - e0, LOCK);

    // R5 + R4 together: tMRD longer than one edge, lockout dominates
    cfg_tmrd = 5; idle(3);
    send(7, 0, 1, e0);
    send(2, 0, 0, e1);
    chk(e1 - e0 == LOCK, "R5 READ after EMRS-on with long tMRD", e1 - e0, LOCK);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule